// File: doc/BRIEF.md
# Bus-Attached Serial Port with Error Flags

This block is a full-duplex asynchronous serial port that sits on a shared 8-bit bidirectional host bus. The host places a byte on the bus and pulses an active-low write strobe. The byte goes into a holding register, and the block then serialises it on its own. A frame is a low start bit, eight data bits sent least significant first, a parity bit and a high stop bit. The parity sense is even or odd, chosen by a configuration input.

Incoming frames are oversampled at sixteen ticks per bit. The tick comes from a fixed divider of the master clock, so one bit lasts `16 × CLK_DIV` clocks. A received byte is held in a receive register and announced on a data-ready output. The host pulls the active-low read strobe low to see the byte on the bus, and that read also clears the status flags. Parity, framing and overrun problems each drive a separate status output. They describe the most recent frame until the next read.

Top module: `uart_bus_port`

## Requirements
- R1: `txLine` is high while `rstN` is low and whenever no frame is being sent. After reset, `txReady` is 1 and `dataReady`, `parityErr`, `framingErr` and `overrun` are all 0.
- R2: A transmitted frame is, in order: start bit (0), data bits 0 to 7 (least significant first), parity bit, stop bit (1). Every bit lasts exactly `16*CLK_DIV` clock cycles.
- R3: With `parityOdd`=0, the parity bit makes the count of ones over data plus parity even. With `parityOdd`=1, that count is odd. This holds for both sent and received frames.
- R4: `txReady` is high when the holding register is empty. A falling edge on `wrN` while `txReady` is high latches `busData`, and `txReady` reads 0 one clock later. The frame then goes out with no further host action. One byte can wait in the holding register while another is being sent.
- R5: A `wrN` falling edge while `txReady` is low is ignored: no extra frame is sent and the held byte is unchanged.
- R6: After a complete received frame, `dataReady` is 1. While `rdN` is low, `busData` carries the received byte. While `rdN` is high, the port does not drive `busData`.
- R7: `parityErr` is 1 after a frame whose parity bit disagrees with the selected sense, and 0 after a frame whose parity agrees.
- R8: `framingErr` is 1 after a frame whose stop-bit sample is 0.
- R9: If a frame completes while `dataReady` is still 1, `overrun` becomes 1 and the newer byte replaces the older one.
- R10: A falling edge on `rdN` clears `dataReady`, `overrun`, `parityErr` and `framingErr`.
- R11: A low pulse on `rxLine` that has ended by the eighth tick after detection is discarded as a glitch: no byte is reported, and a later valid frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| parityOdd | input | 1 | 0 selects even parity, 1 selects odd |
| busData | inout | 8 | Shared host data bus |
| wrN | input | 1 | Active-low write strobe |
| rdN | input | 1 | Active-low read strobe |
| txReady | output | 1 | Holding register empty, host may write |
| dataReady | output | 1 | Received byte waiting |
| parityErr | output | 1 | Last frame failed its parity check |
| framingErr | output | 1 | Last frame had a low stop bit |
| overrun | output | 1 | A byte was overwritten before being read |
| txLine | output | 1 | Serial transmit output |
| rxLine | input | 1 | Serial receive input |

## Verification
The transmit path is driven with random bytes under both parity senses, plus the all-zero and all-ones bytes. This separates bit-order and parity-sense faults from errors in bit length. A back-to-back write sequence sends one byte, holds a second and offers a third while busy, which shows whether the write is properly refused. The receive path gets random good frames, and then frames with corrupted parity, with a low stop bit and with two unread frames in a row. These show whether each flag responds to its own fault alone and whether a read clears them all. A short low pulse on the line, followed by a valid frame, separates correct start-bit qualification from a receiver that triggers on any falling edge.

// File: rtl/uart_bus_pkg.sv
package uart_bus_pkg;

  localparam int TICKS_PER_BIT = 16;
  localparam int MID_TICK      = TICKS_PER_BIT / 2;

  // strobes issued by the control unit to the datapath, one clock each
  typedef struct packed {
    logic wrAccept;  // latch bus byte into holding register
    logic rdClear;   // host read: clear ready and error flags
    logic txLoad;    // move holding register into transmit shifter
    logic txShift;   // advance transmit shifter by one bit
    logic rxShift;   // capture one mid-bit sample
    logic rxFinish;  // last sample of a frame, update receive status
  } ctrlStrobe_t;

endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);

  generate
    if (CLK_DIV > 1) begin : g_div
      localparam int CW = $clog2(CLK_DIV);
      logic [CW-1:0] divCount;

      always_ff @(posedge clk) begin
        if (!rstN)                              divCount <= '0;
        else if (divCount == CW'(CLK_DIV - 1))  divCount <= '0;
        else                                    divCount <= divCount + 1'b1;
      end

      assign tick = (divCount == CW'(CLK_DIV - 1));

      // R2: bit timing relies on ticks never arriving back to back
      assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> !tick);
    end else begin : g_pass
      assign tick = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/uart_ctrl.sv
module uart_ctrl
  import uart_bus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        rxBit,
  input  logic        thrFull,
  input  logic        wrN,
  input  logic        rdN,
  output ctrlStrobe_t strobe,
  output logic        txBusy
);

  localparam int FRAME_BITS = DATA_W + 3;
  localparam int RX_SAMPLES = DATA_W + 2;  // data, parity, stop

  typedef enum logic { TX_IDLE, TX_SEND } txState_t;
  typedef enum logic [1:0] { RX_IDLE, RX_START, RX_DATA } rxState_t;

  txState_t txState;
  rxState_t rxState;
  logic [3:0] txTicks, rxTicks;
  logic [3:0] txBits, rxBits;
  logic wrPrev, rdPrev;

  // host strobe edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPrev <= 1'b1;
      rdPrev <= 1'b1;
    end else begin
      wrPrev <= wrN;
      rdPrev <= rdN;
    end
  end

  logic lastTxTick, lastRxTick, midStartTick;
  assign lastTxTick   = tick && (txTicks == 4'(TICKS_PER_BIT - 1));
  assign lastRxTick   = tick && (rxTicks == 4'(TICKS_PER_BIT - 1));
  assign midStartTick = tick && (rxTicks == 4'(MID_TICK - 1));

  always_comb begin
    strobe          = '0;
    strobe.wrAccept = wrPrev && !wrN && !thrFull;
    strobe.rdClear  = rdPrev && !rdN;
    strobe.txLoad   = (txState == TX_IDLE) && tick && thrFull;
    strobe.txShift  = (txState == TX_SEND) && lastTxTick;
    strobe.rxShift  = (rxState == RX_DATA) && lastRxTick;
    strobe.rxFinish = strobe.rxShift && (rxBits == 4'(RX_SAMPLES - 1));
  end

  assign txBusy = (txState == TX_SEND);

  // transmit sequencing: frame starts on a tick so every bit is 16 ticks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txTicks <= '0;
      txBits  <= '0;
    end else if (strobe.txLoad) begin
      txState <= TX_SEND;
      txTicks <= '0;
      txBits  <= '0;
    end else if (txState == TX_SEND && tick) begin
      txTicks <= txTicks + 1'b1;
      if (lastTxTick) begin
        txBits <= txBits + 1'b1;
        if (txBits == 4'(FRAME_BITS - 1)) txState <= TX_IDLE;
      end
    end
  end

  // receive sequencing: qualify start at mid-bit, then sample every 16 ticks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxTicks <= '0;
      rxBits  <= '0;
    end else if (tick) begin
      unique case (rxState)
        RX_IDLE: begin
          rxTicks <= '0;
          if (!rxBit) rxState <= RX_START;
        end
        RX_START: begin
          if (midStartTick) begin
            rxTicks <= '0;
            rxBits  <= '0;
            rxState <= rxBit ? RX_IDLE : RX_DATA;
          end else begin
            rxTicks <= rxTicks + 1'b1;
          end
        end
        RX_DATA: begin
          rxTicks <= rxTicks + 1'b1;
          if (lastRxTick) begin
            rxBits <= rxBits + 1'b1;
            if (strobe.rxFinish) rxState <= RX_IDLE;
          end
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  // R11: a start sample that reads high must not lead to data sampling
  assert_glitch_dropped_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_START && midStartTick && rxBit) |=> (rxState == RX_IDLE));

endmodule

// File: rtl/uart_datapath.sv
module uart_datapath
  import uart_bus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              txBusy,
  input  logic              parityOdd,
  input  logic              rxLine,
  input  logic [DATA_W-1:0] busIn,
  output logic              rxBit,
  output logic              thrFull,
  output logic              txLine,
  output logic [DATA_W-1:0] rxData,
  output logic              dataReady,
  output logic              parityErr,
  output logic              framingErr,
  output logic              overrun
);

  localparam int FRAME_W = DATA_W + 3;
  localparam int RX_W    = DATA_W + 2;

  logic [DATA_W-1:0]  thrData;
  logic [FRAME_W-1:0] txSr;
  logic [RX_W-2:0]    rxSr;
  logic [RX_W-1:0]    rxNext;
  logic [1:0]         rxSync;

  // transmit holding register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrData <= '0;
      thrFull <= 1'b0;
    end else if (strobe.wrAccept) begin
      thrData <= busIn;
      thrFull <= 1'b1;
    end else if (strobe.txLoad) begin
      thrFull <= 1'b0;
    end
  end

  // transmit shifter: stop, parity, data, start packed LSB-out
  always_ff @(posedge clk) begin
    if (!rstN)
      txSr <= '1;
    else if (strobe.txLoad)
      txSr <= {1'b1, (^thrData) ^ parityOdd, thrData, 1'b0};
    else if (strobe.txShift)
      txSr <= {1'b1, txSr[FRAME_W-1:1]};
  end

  assign txLine = txBusy ? txSr[0] : 1'b1;

  // receive line synchroniser and sample shifter
  always_ff @(posedge clk) begin
    if (!rstN) rxSync <= 2'b11;
    else       rxSync <= {rxSync[0], rxLine};
  end

  assign rxBit  = rxSync[1];
  assign rxNext = {rxBit, rxSr};

  always_ff @(posedge clk) begin
    if (!rstN)               rxSr <= '0;
    else if (strobe.rxShift) rxSr <= rxNext[RX_W-1:1];
  end

  // receive register and status
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData     <= '0;
      dataReady  <= 1'b0;
      parityErr  <= 1'b0;
      framingErr <= 1'b0;
      overrun    <= 1'b0;
    end else if (strobe.rxFinish) begin
      rxData     <= rxNext[DATA_W-1:0];
      dataReady  <= 1'b1;
      parityErr  <= (^rxNext[DATA_W:0]) ^ parityOdd;
      framingErr <= ~rxNext[RX_W-1];
      overrun    <= overrun | dataReady;
    end else if (strobe.rdClear) begin
      dataReady  <= 1'b0;
      parityErr  <= 1'b0;
      framingErr <= 1'b0;
      overrun    <= 1'b0;
    end
  end

  // R2: the first bit after a load is the low start bit
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txLoad |=> !txLine);

  // R4: an accepted write makes the holding register full
  assert_write_fills_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrAccept |=> thrFull);

  // R5: the held byte only changes through an accepted write
  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrAccept |=> $stable(thrData));

  // R9: completing a frame over an unread byte flags overrun
  assert_overrun_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rxFinish && dataReady) |=> overrun);

  // R10: a read with no frame completing clears every flag
  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdClear && !strobe.rxFinish) |=>
      (!dataReady && !overrun && !parityErr && !framingErr));

endmodule

// File: rtl/uart_bus_port.sv
module uart_bus_port
  import uart_bus_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              parityOdd,
  inout  wire  [DATA_W-1:0] busData,
  input  logic              wrN,
  input  logic              rdN,
  output logic              txReady,
  output logic              dataReady,
  output logic              parityErr,
  output logic              framingErr,
  output logic              overrun,
  output logic              txLine,
  input  logic              rxLine
);

  logic              tick, rxBit, thrFull, txBusy;
  logic [DATA_W-1:0] rxData;
  ctrlStrobe_t       strobe;

  uart_tick_gen #(.CLK_DIV(CLK_DIV)) i_tick (
    .clk  (clk),
    .rstN (rstN),
    .tick (tick)
  );

  uart_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .rxBit   (rxBit),
    .thrFull (thrFull),
    .wrN     (wrN),
    .rdN     (rdN),
    .strobe  (strobe),
    .txBusy  (txBusy)
  );

  uart_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .txBusy     (txBusy),
    .parityOdd  (parityOdd),
    .rxLine     (rxLine),
    .busIn      (busData),
    .rxBit      (rxBit),
    .thrFull    (thrFull),
    .txLine     (txLine),
    .rxData     (rxData),
    .dataReady  (dataReady),
    .parityErr  (parityErr),
    .framingErr (framingErr),
    .overrun    (overrun)
  );

  assign txReady = ~thrFull;
  assign busData = rdN ? {DATA_W{1'bz}} : rxData;

  // R1: line idles high whenever the transmit sequencer is not busy
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txLine);

endmodule

// File: tb/test_uart_bus_port.sv
module test_uart_bus_port;

  localparam int CLK_NS  = 10;
  localparam int CLK_DIV = 4;
  localparam int BIT_CLK = 16 * CLK_DIV;
  localparam int BIT_NS  = BIT_CLK * CLK_NS;

  logic clk = 1'b0;
  logic rstN, parityOdd, wrN, rdN, rxLine;
  logic txReady, dataReady, parityErr, framingErr, overrun, txLine;
  logic       busOe;
  logic [7:0] busDrv;
  wire  [7:0] busData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  assign busData = busOe ? busDrv : 8'bz;

  always #(CLK_NS / 2) clk = ~clk;

  uart_bus_port #(.CLK_DIV(CLK_DIV), .DATA_W(8)) i_uart_bus_port (
    .clk        (clk),
    .rstN       (rstN),
    .parityOdd  (parityOdd),
    .busData    (busData),
    .wrN        (wrN),
    .rdN        (rdN),
    .txReady    (txReady),
    .dataReady  (dataReady),
    .parityErr  (parityErr),
    .framingErr (framingErr),
    .overrun    (overrun),
    .txLine     (txLine),
    .rxLine     (rxLine)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic parBit(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk);
    busDrv = d; busOe = 1'b1; wrN = 1'b0;
    @(negedge clk);
    wrN = 1'b1; busOe = 1'b0;
  endtask

  task automatic readByte(output logic [7:0] v);
    @(negedge clk);
    rdN = 1'b0;
    @(negedge clk);
    v = busData;
    rdN = 1'b1;
    @(negedge clk);
  endtask

  task automatic captureFrame(output logic [10:0] bits);
    @(negedge txLine);
    #(BIT_NS / 2 + 3);
    bits[0] = txLine;
    for (int i = 1; i < 11; i++) begin
      #(BIT_NS);
      bits[i] = txLine;
    end
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic p, input logic stopV);
    logic [10:0] f;
    f = {stopV, p, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      rxLine = f[i];
      repeat (BIT_CLK - 1) @(negedge clk);
    end
    @(negedge clk);
    rxLine = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic checkFrame(input logic [10:0] b, input logic [7:0] d, input logic odd);
    check(b[0] == 1'b0, "R2 start", int'(b[0]), 0);
    check(b[8:1] == d, "R2 data", int'(b[8:1]), int'(d));
    check(b[9] == parBit(d, odd), "R3 tx parity", int'(b[9]), int'(parBit(d, odd)));
    check(b[10] == 1'b1, "R2 stop", int'(b[10]), 1);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [10:0] b1, b2;
    logic [7:0]  d, d2, v;
    logic        odd;
    int          lows;
    int unsigned seed;

    seed = $urandom(32'd4321);
    rstN = 1'b0; parityOdd = 1'b0; wrN = 1'b1; rdN = 1'b1;
    rxLine = 1'b1; busOe = 1'b0; busDrv = '0;
    repeat (5) @(negedge clk);
    check(txLine == 1'b1, "R1 tx high in reset", int'(txLine), 1);
    rstN = 1'b1;
    @(negedge clk);
    check(txReady == 1'b1, "R1 txReady after reset", int'(txReady), 1);
    check({dataReady, parityErr, framingErr, overrun} == 4'b0, "R1 flags after reset",
          int'({dataReady, parityErr, framingErr, overrun}), 0);

    // R2 R3 R4: directed and random transmit bytes
    for (int k = 0; k < 8; k++) begin
      if (k == 0)      begin d = 8'h00; odd = 1'b0; end
      else if (k == 1) begin d = 8'hFF; odd = 1'b1; end
      else             begin d = 8'($urandom); odd = 1'($urandom); end
      parityOdd = odd;
      fork
        captureFrame(b1);
        begin
          writeByte(d);
          check(txReady == 1'b0, "R4 txReady drops", int'(txReady), 0);
        end
      join
      checkFrame(b1, d, odd);
      #(BIT_NS);
      @(negedge clk);
      check(txReady == 1'b1, "R4 txReady back", int'(txReady), 1);
      check(txLine == 1'b1, "R1 idle high", int'(txLine), 1);
    end

    // R4 R5: one sending, one held, one refused
    parityOdd = 1'b0;
    d = 8'hA5; d2 = 8'h3C;
    fork
      begin captureFrame(b1); captureFrame(b2); end
      begin
        writeByte(d);
        wait (txReady == 1'b1);
        writeByte(d2);
        writeByte(8'hE7);
      end
    join
    checkFrame(b1, d, 1'b0);
    checkFrame(b2, d2, 1'b0);
    lows = 0;
    repeat (2 * 11 * BIT_CLK) begin
      @(negedge clk);
      if (!txLine) lows++;
    end
    check(lows == 0, "R5 refused write not sent", lows, 0);
    check(txReady == 1'b1, "R5 txReady idle", int'(txReady), 1);

    // R6 R3 R10: good received frames
    for (int k = 0; k < 6; k++) begin
      d = 8'($urandom); odd = 1'($urandom);
      parityOdd = odd;
      sendFrame(d, parBit(d, odd), 1'b1);
      check(dataReady == 1'b1, "R6 dataReady", int'(dataReady), 1);
      check(parityErr == 1'b0, "R3 R7 rx parity ok", int'(parityErr), 0);
      check(framingErr == 1'b0, "R8 no framing error", int'(framingErr), 0);
      readByte(v);
      check(v == d, "R6 bus byte", int'(v), int'(d));
      check(dataReady == 1'b0, "R10 ready cleared", int'(dataReady), 0);
    end

    // R7: wrong parity
    parityOdd = 1'b1; d = 8'h5A;
    sendFrame(d, ~parBit(d, 1'b1), 1'b1);
    check(parityErr == 1'b1, "R7 parity error", int'(parityErr), 1);
    check(framingErr == 1'b0, "R8 framing clean", int'(framingErr), 0);
    readByte(v);
    check(v == d, "R7 byte kept", int'(v), int'(d));
    check(parityErr == 1'b0, "R10 parity cleared", int'(parityErr), 0);

    // R8: low stop bit
    parityOdd = 1'b0; d = 8'hC3;
    sendFrame(d, parBit(d, 1'b0), 1'b0);
    check(framingErr == 1'b1, "R8 framing error", int'(framingErr), 1);
    check(parityErr == 1'b0, "R7 parity clean", int'(parityErr), 0);
    readByte(v);
    check(framingErr == 1'b0, "R10 framing cleared", int'(framingErr), 0);

    // R9: two frames without a read
    d = 8'h11; d2 = 8'h9E;
    sendFrame(d, parBit(d, 1'b0), 1'b1);
    check(overrun == 1'b0, "R9 no overrun yet", int'(overrun), 0);
    sendFrame(d2, parBit(d2, 1'b0), 1'b1);
    check(overrun == 1'b1, "R9 overrun", int'(overrun), 1);
    check(dataReady == 1'b1, "R9 ready", int'(dataReady), 1);
    readByte(v);
    check(v == d2, "R9 newer byte", int'(v), int'(d2));
    check(overrun == 1'b0, "R10 overrun cleared", int'(overrun), 0);

    // R11: short low pulse, then a valid frame
    @(negedge clk);
    rxLine = 1'b0;
    repeat (4 * CLK_DIV) @(negedge clk);
    rxLine = 1'b1;
    repeat (12 * BIT_CLK) @(negedge clk);
    check(dataReady == 1'b0, "R11 glitch ignored", int'(dataReady), 0);
    d = 8'h6B;
    sendFrame(d, parBit(d, 1'b0), 1'b1);
    check(dataReady == 1'b1, "R11 frame after glitch", int'(dataReady), 1);
    readByte(v);
    check(v == d, "R11 byte after glitch", int'(v), int'(d));

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule